// File: doc/BRIEF.md
# Execution-Region Security Monitor

This block sits between the CPU and its memory read path and decides, per access, whether the returned word must be replaced by all zeros. It enforces two fixed rules that are always on. The first blocks instruction fetches from the firmware RAM region. The second blocks any access that falls past the end of physical RAM. Because an all-zero instruction word is illegal, a blocked fetch drives the CPU into its trap state.

A running application can also define one no-execute window. It does this through a base and a limit register on the CPU register bus and then arms the monitor through a control register. Arming cannot be undone, and it freezes the window bounds. Once armed, any fetch from inside the window is blocked.

The block also watches the CPU trap flag. When it sees a trap, it takes over the status LED and blinks it red until the next reset.

Top module: `exec_guard`

## Requirements
- R1: After reset, the control register reads 0, the base and limit registers read 0, `led_override` and `led_red` are 0, and no access is blocked unless a fixed rule matches.
- R2: An instruction fetch (`cpu_valid`=1, `cpu_ifetch`=1) to an address from `FW_BASE` through `FW_BASE+FW_BYTES-1` drives `force_zero`=1 in the same cycle, whether the monitor is armed or not. A data access (`cpu_ifetch`=0) to that region is not blocked.
- R3: Any access, fetch or data, to an address from `RAM_BASE+RAM_BYTES` through `RAM_SPACE_LAST` drives `force_zero`=1 in the same cycle.
- R4: Register offsets are fixed: control at 0x60 (bit 0 = armed), window base at 0x61 and window limit at 0x62. Base and limit are full 32-bit registers. A read returns the register's value while `reg_cs`=1 and `reg_we`=0. A write takes effect from the next cycle.
- R5: Writing 1 to bit 0 of the control register arms the monitor. After that, no write, including a write of 0, disarms it.
- R6: While the monitor is armed, writes to the base and limit registers are ignored and their read values stay unchanged.
- R7: While the monitor is armed, a fetch whose address satisfies base <= addr <= limit (both ends inclusive) drives `force_zero`=1. Data accesses in the window, and fetches just outside it, are not blocked. While the monitor is not armed, the window has no effect.
- R8: When `cpu_valid`=0, `force_zero` is 0.
- R9: A `cpu_trap` high at a rising clock edge sets `led_override` from the next cycle. It stays set until reset, even after `cpu_trap` falls.
- R10: While `led_override` is 1, `led_red` follows bit `BLINK_BIT` of a free-running cycle counter, so its high and low phases each last 2^`BLINK_BIT` cycles. While `led_override` is 0, `led_red` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register bus select |
| reg_we | input | 1 | Register bus write enable |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| cpu_valid | input | 1 | CPU access in progress |
| cpu_ifetch | input | 1 | Access is an instruction fetch |
| cpu_addr | input | 32 | Access address |
| cpu_trap | input | 1 | CPU has entered its trap state |
| force_zero | output | 1 | Select all-zero read data for this access |
| led_override | output | 1 | Monitor owns the status LED |
| led_red | output | 1 | Red LED drive while overriding |

## Verification
The bench keeps the default address map: 2 KiB of firmware RAM at 0xD000_0000 and 128 KiB of RAM at 0x4000_0000, with the RAM space ending at 0x7FFF_FFFF. These defaults put both fixed-rule edges and the window edges within reach of directed addresses. `BLINK_BIT` is lowered to 3, so a full blink period lasts 16 cycles and the bench can measure both phase lengths exactly. Random addresses are drawn from buckets on and around every region edge, with random fetch and valid flags, once before arming and once after.

// File: rtl/exg_pkg.sv
package exg_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h60;
  localparam logic [OFS_W-1:0] OFS_BASE  = 8'h61;
  localparam logic [OFS_W-1:0] OFS_LIMIT = 8'h62;

  // Inclusive span test shared by the rule logic and its checks.
  function automatic logic in_span(input addr_t a, input addr_t lo, input addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/exg_regs.sv
module exg_regs
  import exg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic [OFS_W-1:0] addr,
  input  addr_t            wdata,
  output addr_t            rdata,
  output logic             armed,
  output addr_t            win_base,
  output addr_t            win_limit
);
  logic  armed_q;
  addr_t base_q, limit_q;
  logic  wr_ctrl, wr_base, wr_limit;

  assign wr_ctrl  = cs && we && (addr == OFS_CTRL);
  assign wr_base  = cs && we && (addr == OFS_BASE)  && !armed_q;
  assign wr_limit = cs && we && (addr == OFS_LIMIT) && !armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (wr_ctrl && wdata[0]) armed_q <= 1'b1;
      if (wr_base)  base_q  <= wdata;
      if (wr_limit) limit_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && !we) begin
      unique case (addr)
        OFS_CTRL:  rdata = {{(ADDR_W-1){1'b0}}, armed_q};
        OFS_BASE:  rdata = base_q;
        OFS_LIMIT: rdata = limit_q;
        default:   rdata = '0;
      endcase
    end
  end

  assign armed     = armed_q;
  assign win_base  = base_q;
  assign win_limit = limit_q;

  p_arm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  p_bounds_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ($stable(base_q) && $stable(limit_q)));
endmodule

// File: rtl/exg_rules.sv
module exg_rules
  import exg_pkg::*;
#(
  parameter addr_t FW_BASE        = 32'hD000_0000,
  parameter addr_t FW_BYTES       = 32'h0000_0800,
  parameter addr_t RAM_BASE       = 32'h4000_0000,
  parameter addr_t RAM_BYTES      = 32'h0002_0000,
  parameter addr_t RAM_SPACE_LAST = 32'h7FFF_FFFF
) (
  input  addr_t cpu_addr,
  input  logic  cpu_valid,
  input  logic  cpu_ifetch,
  input  logic  armed,
  input  addr_t win_base,
  input  addr_t win_limit,
  output logic  fixed_hit,
  output logic  window_hit,
  output logic  force_zero
);
  localparam int    N_FIXED = 2;
  localparam addr_t FW_LAST = FW_BASE + FW_BYTES - 1;
  localparam addr_t RAM_END = RAM_BASE + RAM_BYTES;
  // rule 0: firmware RAM, fetch only; rule 1: past end of RAM, any access
  localparam logic [N_FIXED-1:0][ADDR_W-1:0] RULE_LO = {RAM_END, FW_BASE};
  localparam logic [N_FIXED-1:0][ADDR_W-1:0] RULE_HI = {RAM_SPACE_LAST, FW_LAST};
  localparam logic [N_FIXED-1:0]             RULE_FETCH_ONLY = 2'b01;

  logic [N_FIXED-1:0] rule_hit;

  for (genvar g = 0; g < N_FIXED; g++) begin : g_rule
    assign rule_hit[g] = in_span(cpu_addr, RULE_LO[g], RULE_HI[g]) &&
                         (cpu_ifetch || !RULE_FETCH_ONLY[g]);
  end

  assign fixed_hit  = |rule_hit;
  assign window_hit = armed && cpu_ifetch && in_span(cpu_addr, win_base, win_limit);
  assign force_zero = cpu_valid && (fixed_hit || window_hit);

  always_comb begin
    if (!cpu_valid) a_idle_r8: assert (!force_zero);
  end
endmodule

// File: rtl/exg_trap_led.sv
module exg_trap_led #(
  parameter int BLINK_BIT = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_trap,
  output logic led_override,
  output logic led_red
);
  localparam int CNT_W = BLINK_BIT + 1;

  logic             trap_seen_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_seen_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cpu_trap) trap_seen_q <= 1'b1;
    end
  end

  assign led_override = trap_seen_q;
  assign led_red      = trap_seen_q && cnt_q[BLINK_BIT];

  p_trap_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_trap |=> led_override);
  p_trap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    led_override |=> led_override);
  p_red_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    led_red |-> led_override);
endmodule

// File: rtl/exec_guard.sv
module exec_guard
  import exg_pkg::*;
#(
  parameter addr_t FW_BASE        = 32'hD000_0000,
  parameter addr_t FW_BYTES       = 32'h0000_0800,
  parameter addr_t RAM_BASE       = 32'h4000_0000,
  parameter addr_t RAM_BYTES      = 32'h0002_0000,
  parameter addr_t RAM_SPACE_LAST = 32'h7FFF_FFFF,
  parameter int    BLINK_BIT      = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_cs,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cpu_valid,
  input  logic        cpu_ifetch,
  input  logic [31:0] cpu_addr,
  input  logic        cpu_trap,
  output logic        force_zero,
  output logic        led_override,
  output logic        led_red
);
  localparam addr_t FW_LAST = FW_BASE + FW_BYTES - 1;

  logic  armed;
  addr_t win_base, win_limit;
  logic  fixed_hit, window_hit;

  exg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs(reg_cs), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .armed(armed),
    .win_base(win_base), .win_limit(win_limit)
  );

  exg_rules #(
    .FW_BASE(FW_BASE), .FW_BYTES(FW_BYTES), .RAM_BASE(RAM_BASE),
    .RAM_BYTES(RAM_BYTES), .RAM_SPACE_LAST(RAM_SPACE_LAST)
  ) u_rules (
    .cpu_addr(cpu_addr), .cpu_valid(cpu_valid), .cpu_ifetch(cpu_ifetch),
    .armed(armed), .win_base(win_base), .win_limit(win_limit),
    .fixed_hit(fixed_hit), .window_hit(window_hit), .force_zero(force_zero)
  );

  exg_trap_led #(.BLINK_BIT(BLINK_BIT)) u_led (
    .clk(clk), .rst_n(rst_n), .cpu_trap(cpu_trap),
    .led_override(led_override), .led_red(led_red)
  );

  p_fw_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ifetch && in_span(cpu_addr, FW_BASE, FW_LAST)) |-> force_zero);
  p_window_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    window_hit |-> (reg_rdata == 32'h0 || armed) && armed);
  p_block_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |-> (fixed_hit || window_hit));
endmodule

// File: tb/sim_exec_guard.sv
`timescale 1ns/1ps
module sim_exec_guard;
  localparam logic [31:0] FWB   = 32'hD000_0000;
  localparam logic [31:0] FWL   = 32'hD000_07FF;
  localparam logic [31:0] RAMB  = 32'h4000_0000;
  localparam logic [31:0] RAME  = 32'h4002_0000;
  localparam logic [31:0] SPL   = 32'h7FFF_FFFF;
  localparam int          BB    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_cs = 0, reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, cpu_addr = 0;
  logic cpu_valid = 0, cpu_ifetch = 0, cpu_trap = 0;
  logic force_zero, led_override, led_red;

  int tests = 0, fails = 0;
  bit done = 0;
  logic m_arm = 0;
  logic [31:0] m_base = 0, m_limit = 0;

  always #2.5 clk = ~clk;

  exec_guard #(.BLINK_BIT(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_valid(cpu_valid), .cpu_ifetch(cpu_ifetch), .cpu_addr(cpu_addr),
    .cpu_trap(cpu_trap), .force_zero(force_zero),
    .led_override(led_override), .led_red(led_red)
  );

  function automatic bit expect_block(logic [31:0] a, bit v, bit f);
    bit fw, oor, win;
    fw  = f && !(a < FWB) && !(a > FWL);
    oor = !(a < RAME) && !(a > SPL);
    win = m_arm && f && !(a < m_base) && !(a > m_limit);
    return v && (fw || oor || win);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 0; reg_we = 0;
  endtask

  task automatic rd_check(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_cs = 1; reg_we = 0; reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
    reg_cs = 0;
  endtask

  task automatic access(logic [31:0] a, bit v, bit f, string req);
    bit e;
    @(negedge clk);
    cpu_addr = a; cpu_valid = v; cpu_ifetch = f;
    #1;
    e = expect_block(a, v, f);
    check(force_zero == e, req, {31'b0, force_zero}, {31'b0, e});
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] c [12];
    c[0] = FWB; c[1] = FWL; c[2] = FWL + 1; c[3] = FWB - 1;
    c[4] = RAME - 1; c[5] = RAME; c[6] = SPL; c[7] = SPL + 1;
    c[8] = m_base; c[9] = m_limit; c[10] = m_base - 1; c[11] = m_limit + 1;
    if ($urandom_range(3) == 0) return $urandom;
    return c[$urandom_range(11)];
  endfunction

  task automatic random_phase(int n, string req);
    for (int i = 0; i < n; i++)
      access(pick_addr(), $urandom_range(3) != 0, $urandom_range(1) == 1, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_check(8'h60, 32'h0, "R1");
    rd_check(8'h61, 32'h0, "R1");
    rd_check(8'h62, 32'h0, "R1");
    check(led_override == 0 && led_red == 0, "R1", {30'b0, led_override, led_red}, 0);
    access(RAMB + 32'h10, 1, 1, "R1");
    // R2 fixed firmware fetch rule
    access(FWB, 1, 1, "R2"); access(FWL, 1, 1, "R2");
    access(FWL + 1, 1, 1, "R2"); access(FWB + 4, 1, 0, "R2");
    // R3 beyond RAM
    access(RAME, 1, 0, "R3"); access(RAME - 1, 1, 0, "R3");
    access(SPL, 1, 1, "R3"); access(SPL + 1, 1, 0, "R3");
    // R8 idle
    access(FWB, 0, 1, "R8"); access(RAME, 0, 0, "R8");
    // R4 register map
    wr(8'h61, RAMB + 32'h100); m_base = RAMB + 32'h100;
    wr(8'h62, RAMB + 32'h1FF); m_limit = RAMB + 32'h1FF;
    rd_check(8'h61, m_base, "R4");
    rd_check(8'h62, m_limit, "R4");
    // R7 window inactive while unarmed
    access(m_base, 1, 1, "R7");
    random_phase(300, "R7");
    // R5 arm
    wr(8'h60, 32'h1); m_arm = 1;
    rd_check(8'h60, 32'h1, "R5");
    wr(8'h60, 32'h0);
    rd_check(8'h60, 32'h1, "R5");
    // R6 bounds frozen
    wr(8'h61, 32'h1234_5678); wr(8'h62, 32'hFFFF_FFFF);
    rd_check(8'h61, m_base, "R6");
    rd_check(8'h62, m_limit, "R6");
    // R7 inclusive window
    access(m_base, 1, 1, "R7"); access(m_limit, 1, 1, "R7");
    access(m_base - 1, 1, 1, "R7"); access(m_limit + 1, 1, 1, "R7");
    access(m_base + 8, 1, 0, "R7");
    random_phase(300, "R7");
    access(FWB, 1, 1, "R2");
    // R9 trap latching
    @(negedge clk); cpu_valid = 0;
    check(led_override == 0, "R9", {31'b0, led_override}, 0);
    cpu_trap = 1;
    @(negedge clk); cpu_trap = 0;
    check(led_override == 1, "R9", {31'b0, led_override}, 1);
    repeat (20) @(negedge clk);
    check(led_override == 1, "R9", {31'b0, led_override}, 1);
    // R10 blink phase lengths
    begin
      int hi = 0, lo = 0, guard = 0;
      logic prev;
      prev = led_red;
      while (!(prev == 0 && led_red == 1) && guard < 40) begin
        prev = led_red; @(negedge clk); guard++;
      end
      while (led_red == 1 && hi < 40) begin hi++; @(negedge clk); end
      while (led_red == 0 && lo < 40) begin lo++; @(negedge clk); end
      check(hi == (1 << BB), "R10", hi, 1 << BB);
      check(lo == (1 << BB), "R10", lo, 1 << BB);
    end
    // R1 reset clears trap
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check(led_override == 0 && led_red == 0, "R1", {30'b0, led_override, led_red}, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule